// File: doc/BRIEF.md
# Switch-Coded Four-Digit Keypad Lock

This block is the control core of a keypad door lock. Hexadecimal key codes arrive one at a time on a valid/ready input stream. Each accepted digit enters a 16-bit entry register from the right, the way a calculator display fills, and the earlier digits move one place to the left. The register value is driven out so that four 7-segment digits can show what has been typed. The block has a control state machine and a datapath. One load strobe from the controller both shifts the register and advances a digit counter.

When the fourth digit has been captured, the register is compared with a secret code set on sixteen external switches, four switches per hex digit. On a match, the open output goes high for a fixed hold time, which is ten seconds of the configured clock by default. The entry register is cleared while the door is open. On a mismatch, the controller spends one cycle clearing the register and then waits for a new first digit.

Back-pressure rules: `key_ready` is high only while the block is collecting digits and fewer than four have been captured. A digit is taken on a clock edge where both `key_valid` and `key_ready` are high. While `key_ready` is low, an offered digit is not taken and has no effect on the block. The source may hold it or withdraw it.

Top module: `keylock_top`

## Requirements
- R1: After reset, `open_o` is 0, `entry_o` is 16'h0000 and `key_ready` is 1.
- R2: An accepted digit shifts `entry_o` left by four bits and places the digit in bits 3:0. The new value is visible in the cycle after the accepting edge.
- R3: `key_ready` goes low in the cycle after the fourth digit is accepted, so no fifth digit can be taken before the compare.
- R4: The comparison takes place only when four digits are held. On a match, `open_o` rises on the second clock edge after the fourth digit is accepted.
- R5: `open_o` stays high for exactly HOLD_CYCLES = CLK_HZ*HOLD_S cycles (2000 by default). It then falls, and `key_ready` returns to 1 in the same cycle.
- R6: While the door is open, the entry register is cleared. `entry_o` reads 16'h0000 from the cycle after `open_o` rises.
- R7: On a mismatch, `open_o` stays 0. `key_ready` stays low for two cycles after the fourth digit is accepted, and `entry_o` is 16'h0000 when `key_ready` returns.
- R8: A digit offered while `key_ready` is low, including during the open hold, leaves `entry_o` unchanged.
- R9: The first digit entered is matched against `code_sw[15:12]` and the last against `code_sw[3:0]`, so the digit order matters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_valid | input | 1 | A key digit is offered |
| key_ready | output | 1 | The block can take a digit |
| key_data | input | 4 | Hex value of the offered digit |
| code_sw | input | 16 | Secret code, four hex digits, first digit in the top nibble |
| open_o | output | 1 | Door release, high during the hold time |
| entry_o | output | 16 | Entry register contents for display |

## Verification
The assertions assume that `code_sw` does not change during an attempt. The match check relates the switch value to the register contents one cycle before the open output rises. The bench therefore changes the switches only while the register is empty and idle. Key signals are driven on the falling clock edge. Where the bench offers a digit while `key_ready` is low, it withdraws `key_valid` before `key_ready` can return, so an ignored digit is never taken late.

// File: rtl/keylock_pkg.sv
package keylock_pkg;
  typedef enum logic [1:0] {
    ST_COLLECT = 2'd0,
    ST_OPEN    = 2'd1,
    ST_FAIL    = 2'd2
  } lock_state_e;
endpackage

// File: rtl/keylock_entry.sv
// Entry shift register and digit counter (datapath).
module keylock_entry #(
  parameter int DIGITS  = 4,
  parameter int DIGIT_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ld,
  input  logic                        clr,
  input  logic [DIGIT_W-1:0]          key,
  output logic [DIGITS*DIGIT_W-1:0]   entry,
  output logic                        full
);
  localparam int W  = DIGITS * DIGIT_W;
  localparam int CW = $clog2(DIGITS + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DIGITS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      entry <= '0;
      cnt   <= '0;
    end else if (clr) begin
      entry <= '0;
      cnt   <= '0;
    end else if (ld) begin
      entry <= {entry[W-DIGIT_W-1:0], key};
      cnt   <= cnt + 1'b1;
    end
  end

  assign full = (cnt == CNT_FULL);

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_FULL);

  // R3
  no_load_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !ld);
endmodule

// File: rtl/keylock_hold.sv
// Terminal-count timer for the door hold time.
module keylock_hold #(
  parameter int HOLD_CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end

  assign done = run && (cnt == LAST);

  // R5
  hold_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
endmodule

// File: rtl/keylock_ctrl.sv
// Control state machine for the lock.
module keylock_ctrl
  import keylock_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic key_valid,
  input  logic full,
  input  logic match,
  input  logic hold_done,
  output logic key_ready,
  output logic ld,
  output logic clr,
  output logic open
);
  lock_state_e state, state_nx;

  always_comb begin
    state_nx = state;
    case (state)
      ST_COLLECT: if (full) state_nx = match ? ST_OPEN : ST_FAIL;
      ST_OPEN:    if (hold_done) state_nx = ST_COLLECT;
      ST_FAIL:    state_nx = ST_COLLECT;
      default:    state_nx = ST_COLLECT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_COLLECT;
    else        state <= state_nx;
  end

  assign key_ready = (state == ST_COLLECT) && !full;
  assign ld        = key_valid && key_ready;
  assign open      = (state == ST_OPEN);
  assign clr       = (state == ST_OPEN) || (state == ST_FAIL);

  // R7
  fail_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FAIL) |=> (state == ST_COLLECT));

  // R8
  open_blocks_keys_chk: assert property (@(posedge clk) disable iff (!rst_n)
    open |-> !key_ready);
endmodule

// File: rtl/keylock_top.sv
module keylock_top #(
  parameter int DIGITS  = 4,
  parameter int DIGIT_W = 4,
  parameter int CLK_HZ  = 200,
  parameter int HOLD_S  = 10
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      key_valid,
  output logic                      key_ready,
  input  logic [DIGIT_W-1:0]        key_data,
  input  logic [DIGITS*DIGIT_W-1:0] code_sw,
  output logic                      open_o,
  output logic [DIGITS*DIGIT_W-1:0] entry_o
);
  localparam int HOLD_CYCLES = CLK_HZ * HOLD_S;

  logic ld, clr, full, match, hold_done;

  keylock_entry #(.DIGITS(DIGITS), .DIGIT_W(DIGIT_W)) u_entry (
    .clk(clk), .rst_n(rst_n), .ld(ld), .clr(clr), .key(key_data),
    .entry(entry_o), .full(full)
  );

  keylock_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk(clk), .rst_n(rst_n), .run(open_o), .done(hold_done)
  );

  keylock_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .full(full),
    .match(match), .hold_done(hold_done), .key_ready(key_ready),
    .ld(ld), .clr(clr), .open(open_o)
  );

  assign match = (entry_o == code_sw);

  // R4
  open_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open_o) |-> ($past(entry_o) == $past(code_sw)));

  // R6
  cleared_after_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(open_o) |-> (entry_o == '0));

  // R5
  ready_after_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(open_o) |-> key_ready);
endmodule

// File: tb/test_keylock_top.sv
`timescale 1ns/1ps
module test_keylock_top;
  localparam int HOLD = 200 * 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        key_valid = 1'b0;
  logic        key_ready;
  logic [3:0]  key_data = '0;
  logic [15:0] code_sw = 16'h13B7;
  logic        open_o;
  logic [15:0] entry_o;

  int vectors = 0;
  int errors  = 0;
  logic [15:0] model = '0;
  logic [15:0] exp_q[$];
  logic took = 1'b0;

  always #10 clk = ~clk;

  keylock_top i_keylock_top (
    .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_ready(key_ready),
    .key_data(key_data), .code_sw(code_sw), .open_o(open_o), .entry_o(entry_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pop expected display values after each accepted digit
  always @(posedge clk) took <= key_valid && key_ready;
  always @(negedge clk) begin
    if (took) begin
      if (exp_q.size() == 0) check("R2 unexpected accept", 32'(entry_o), 32'hFFFF_FFFF);
      else check("R2 shift", 32'(entry_o), 32'(exp_q.pop_front()));
    end
  end

  // driver: send one digit, returns on the negedge after acceptance
  task automatic send(input logic [3:0] d);
    @(negedge clk);
    while (!key_ready) @(negedge clk);
    key_valid = 1'b1;
    key_data  = d;
    model = {model[11:0], d};
    exp_q.push_back(model);
    @(negedge clk);
    key_valid = 1'b0;
  endtask

  task automatic send4(input logic [15:0] c);
    send(c[15:12]); send(c[11:8]); send(c[7:4]); send(c[3:0]);
  endtask

  task automatic expect_open(input logic [15:0] c);
    int n;
    check("R3 ready low after 4th", 32'(key_ready), 32'd0);
    check("R4 no open before compare", 32'(open_o), 32'd0);
    @(negedge clk);
    check("R4 open rises", 32'(open_o), 32'd1);
    check("R9 code shown at open", 32'(entry_o), 32'(c));
    // R8: offer a digit during the hold; it must be ignored
    key_valid = 1'b1; key_data = 4'h5;
    @(negedge clk);
    check("R6 cleared during open", 32'(entry_o), 32'd0);
    key_valid = 1'b0;
    n = 2;
    while (open_o && n < HOLD + 10) begin
      @(negedge clk);
      if (open_o) n++;
    end
    check("R5 hold length", 32'(n), 32'(HOLD));
    check("R5 ready after hold", 32'(key_ready), 32'd1);
    check("R8 digit in hold ignored", 32'(entry_o), 32'd0);
    model = '0;
  endtask

  task automatic expect_fail();
    check("R3 ready low after 4th", 32'(key_ready), 32'd0);
    @(negedge clk);
    check("R7 no open", 32'(open_o), 32'd0);
    check("R7 ready still low", 32'(key_ready), 32'd0);
    @(negedge clk);
    check("R7 no open later", 32'(open_o), 32'd0);
    check("R7 ready back", 32'(key_ready), 32'd1);
    check("R7 cleared", 32'(entry_o), 32'd0);
    model = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R5 actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 open", 32'(open_o), 32'd0);
    check("R1 entry", 32'(entry_o), 32'd0);
    check("R1 ready", 32'(key_ready), 32'd1);

    send4(16'h13B7);           // R2 R4 R9 match
    expect_open(16'h13B7);

    send4(16'h13B6);           // R7 mismatch
    expect_fail();

    // R8: offer a fifth digit while ready is low after the 4th
    send4(16'h2222);
    key_valid = 1'b1; key_data = 4'h9;
    @(negedge clk);
    key_valid = 1'b0;
    check("R8 fifth digit ignored", 32'(entry_o), 32'h2222);
    @(negedge clk);
    check("R7 no open on 2222", 32'(open_o), 32'd0);
    model = '0;
    repeat (2) @(negedge clk);

    code_sw = 16'hA0F2;        // R9 order matters
    send4(16'h2F0A);
    expect_fail();
    send4(16'hA0F2);
    expect_open(16'hA0F2);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule